// File: doc/BRIEF.md
# Trace Output Write Pointer

This block produces the physical byte address to which the next byte of trace output is written. It also checks whether the programmed offset is legal at the moment tracing is switched on. A mode input selects between two addressing schemes. In single-region mode the address is a fixed output base plus a 32-bit offset, and a limit bounds the offset inclusively. In table mode the address is the region base of the current table entry plus the offset, and the entry's size bounds the offset exclusively. The table entry itself is supplied by surrounding logic.

Output bytes arrive on a valid/ready stream. A byte is taken in any cycle where `wr_valid` and `wr_ready` are both high, and `wr_addr` in that cycle is where the byte goes. The producer may hold `wr_valid` high for as long as it needs. While `wr_ready` is low, no byte is taken and the offset does not move. `wr_ready` is low during reset, while tracing is off, in the first cycle tracing is on, and whenever the error flag is set.

While tracing is off, software can load the offset directly. A failed legality check sets a sticky error flag. Only a software clear removes it.

Top module: `trace_wptr`

## Requirements
- R1: After reset the offset is 0, `op_err` is 0, `region_adv` is 0 and `wr_ready` is 0.
- R2: When `mode_table` is 0, `wr_addr` equals `out_base` plus the zero-extended offset, modulo 2^ADDR_W.
- R3: When `mode_table` is 1, `wr_addr` equals `ent_base` plus the zero-extended offset, modulo 2^ADDR_W.
- R4: Each accepted byte (`wr_valid` and `wr_ready` both 1) advances the offset by one, unless R5 or R6 applies.
- R5: In single-region mode, a byte accepted at an offset equal to `out_limit` returns the offset to 0.
- R6: In table mode, a byte accepted where offset+1 >= `ent_size` returns the offset to 0 and raises `region_adv` for exactly the following cycle.
- R7: In the cycle where `trace_en` rises in single-region mode, an offset greater than `out_limit` sets `op_err` from the next cycle. An offset equal to the limit does not.
- R8: In the cycle where `trace_en` rises in table mode, an offset greater than or equal to `ent_size` sets `op_err` from the next cycle. An offset of `ent_size`-1 does not.
- R9: `op_err` stays set until `err_clr` is 1. If a failed check and a clear occur in the same cycle, the error is set.
- R10: `wr_ready` is 1 only when `trace_en` was already 1 in the previous cycle and `op_err` is 0. While `op_err` is set, the offset does not change.
- R11: `ofs_wr` loads `ofs_wdata` into the offset only while `trace_en` is 0. While tracing is on, `ofs_wr` is ignored.
- R12: The legality check runs only on the rising edge of `trace_en`. Changing the limit, size or offset while tracing stays on never sets `op_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_table | input | 1 | 0 = single-region addressing, 1 = table addressing |
| trace_en | input | 1 | Tracing enabled |
| out_base | input | ADDR_W | Base address of the single output region |
| out_limit | input | OFS_W | Inclusive offset limit in single-region mode |
| ent_base | input | ADDR_W | Region base from the current table entry |
| ent_size | input | OFS_W | Region size in bytes from the current table entry |
| ofs_wr | input | 1 | Software load strobe for the offset |
| ofs_wdata | input | OFS_W | Value to load into the offset |
| err_clr | input | 1 | Software clear of the error flag |
| wr_valid | input | 1 | Trace byte offered |
| wr_ready | output | 1 | Trace byte can be taken this cycle |
| wr_addr | output | ADDR_W | Physical address for the current byte |
| cur_ofs | output | OFS_W | Current offset value |
| op_err | output | 1 | Sticky operational error |
| region_adv | output | 1 | One-cycle request to move to the next table entry |

## Verification
The assertions check the following properties on every cycle:
- `wr_ready` stays low while the error is set and in the first cycle after enable.
- The error can only appear directly after tracing is on, and it persists until cleared.
- `region_adv` only follows an accepted table-mode byte.
- In single-region mode the offset steps by one or wraps at the limit.
- The offset holds while tracing is on and no byte is taken.

Some behaviours depend on values chosen by the bench and are shown only by its scenarios:
- The exact comparison boundaries (limit against limit+1, size-1 against size).
- A clear arriving in the same cycle as a failed check.
- A size of 1 that advances the region on every byte.
- Limit changes made while tracing runs.

For these, the reference model tracks the offset and flags cycle by cycle.

// File: rtl/tow_pkg.sv
package tow_pkg;
  // next-value selection for the offset register
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2,
    ACT_WRAP = 2'd3
  } ofs_act_e;
endpackage

// File: rtl/tow_bound.sv
module tow_bound #(
  parameter int OFS_W = 32
) (
  input  logic             mode_table,
  input  logic [OFS_W-1:0] ofs,
  input  logic [OFS_W-1:0] out_limit,
  input  logic [OFS_W-1:0] ent_size,
  output logic             illegal,
  output logic             at_end
);
  localparam int EXT_W = OFS_W + 1;

  logic [EXT_W-1:0] ofs_x;
  logic [EXT_W-1:0] ofs_inc;
  logic [EXT_W-1:0] size_x;

  always_comb begin
    ofs_x   = {1'b0, ofs};
    ofs_inc = ofs_x + EXT_W'(1);
    size_x  = {1'b0, ent_size};
    if (mode_table) begin
      illegal = (ofs_x >= size_x);
      at_end  = (ofs_inc >= size_x);
    end else begin
      illegal = (ofs > out_limit);
      at_end  = (ofs == out_limit);
    end
  end
endmodule

// File: rtl/tow_offset_ctr.sv
module tow_offset_ctr
  import tow_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ofs_act_e         act,
  input  logic [OFS_W-1:0] ld_val,
  output logic [OFS_W-1:0] ofs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: ofs <= ld_val;
        ACT_STEP: ofs <= ofs + OFS_W'(1);
        ACT_WRAP: ofs <= '0;
        default:  ofs <= ofs;
      endcase
    end
  end
endmodule

// File: rtl/tow_err_ctl.sv
module tow_err_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_en,
  input  logic illegal,
  input  logic err_clr,
  output logic en_q,
  output logic op_err,
  output logic wr_ready
);
  logic arm;

  assign arm      = trace_en & ~en_q;
  assign wr_ready = trace_en & en_q & ~op_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      op_err <= 1'b0;
    end else begin
      en_q <= trace_en;
      if (arm && illegal)
        op_err <= 1'b1;
      else if (err_clr)
        op_err <= 1'b0;
    end
  end
endmodule

// File: rtl/tow_addr_gen.sv
module tow_addr_gen #(
  parameter int ADDR_W = 48,
  parameter int OFS_W  = 32
) (
  input  logic              mode_table,
  input  logic [ADDR_W-1:0] out_base,
  input  logic [ADDR_W-1:0] ent_base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] base_sel;

  generate
    if (ADDR_W > OFS_W) begin : g_wide
      assign ofs_ext = {{(ADDR_W-OFS_W){1'b0}}, ofs};
    end else begin : g_narrow
      assign ofs_ext = ofs[ADDR_W-1:0];
    end
  endgenerate

  assign base_sel = mode_table ? ent_base : out_base;
  assign addr     = base_sel + ofs_ext;
endmodule

// File: rtl/trace_wptr.sv
module trace_wptr
  import tow_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_table,
  input  logic              trace_en,
  input  logic [ADDR_W-1:0] out_base,
  input  logic [OFS_W-1:0]  out_limit,
  input  logic [ADDR_W-1:0] ent_base,
  input  logic [OFS_W-1:0]  ent_size,
  input  logic              ofs_wr,
  input  logic [OFS_W-1:0]  ofs_wdata,
  input  logic              err_clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [OFS_W-1:0]  cur_ofs,
  output logic              op_err,
  output logic              region_adv
);
  logic     illegal;
  logic     at_end;
  logic     en_q;
  logic     accept;
  ofs_act_e act;

  tow_bound #(.OFS_W(OFS_W)) bound_i (
    .mode_table (mode_table),
    .ofs        (cur_ofs),
    .out_limit  (out_limit),
    .ent_size   (ent_size),
    .illegal    (illegal),
    .at_end     (at_end)
  );

  tow_err_ctl err_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trace_en (trace_en),
    .illegal  (illegal),
    .err_clr  (err_clr),
    .en_q     (en_q),
    .op_err   (op_err),
    .wr_ready (wr_ready)
  );

  assign accept = wr_valid & wr_ready;

  always_comb begin
    if (!trace_en && ofs_wr)
      act = ACT_LOAD;
    else if (accept)
      act = at_end ? ACT_WRAP : ACT_STEP;
    else
      act = ACT_HOLD;
  end

  tow_offset_ctr #(.OFS_W(OFS_W)) ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .ld_val (ofs_wdata),
    .ofs    (cur_ofs)
  );

  tow_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) addr_i (
    .mode_table (mode_table),
    .out_base   (out_base),
    .ent_base   (ent_base),
    .ofs        (cur_ofs),
    .addr       (wr_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      region_adv <= 1'b0;
    else
      region_adv <= accept & mode_table & at_end;
  end
endmodule

// File: rtl/trace_wptr_chk.sv
module trace_wptr_chk #(
  parameter int ADDR_W = 48,
  parameter int OFS_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_table,
  input logic             trace_en,
  input logic [OFS_W-1:0] out_limit,
  input logic             err_clr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [OFS_W-1:0] cur_ofs,
  input logic             op_err,
  input logic             region_adv
);
  a_r10_no_ready_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !wr_ready);

  a_r10_no_ready_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_en) |-> !wr_ready);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (op_err && !err_clr) |=> op_err);

  a_r7_err_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_err) |-> $past(trace_en));

  a_r6_adv_after_table_byte: assert property (@(posedge clk) disable iff (!rst_n)
    region_adv |-> $past(mode_table && wr_valid && wr_ready));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !mode_table && cur_ofs != out_limit)
      |=> cur_ofs == $past(cur_ofs) + OFS_W'(1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !mode_table && cur_ofs == out_limit)
      |=> cur_ofs == '0);

  a_r11_hold_while_tracing: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && !(wr_valid && wr_ready)) |=> $stable(cur_ofs));
endmodule

bind trace_wptr trace_wptr_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_table (mode_table),
  .trace_en   (trace_en),
  .out_limit  (out_limit),
  .err_clr    (err_clr),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .cur_ofs    (cur_ofs),
  .op_err     (op_err),
  .region_adv (region_adv)
);

// File: tb/trace_wptr_tb_top.sv
module trace_wptr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int OW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_table = 1'b0;
  logic          trace_en = 1'b0;
  logic [AW-1:0] out_base = '0;
  logic [OW-1:0] out_limit = '0;
  logic [AW-1:0] ent_base = '0;
  logic [OW-1:0] ent_size = '0;
  logic          ofs_wr = 1'b0;
  logic [OW-1:0] ofs_wdata = '0;
  logic          err_clr = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [OW-1:0] cur_ofs;
  logic          op_err;
  logic          region_adv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  longint m_ofs = 0;
  bit     m_err = 0;
  bit     m_en_q = 0;
  bit     m_adv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_wptr #(.ADDR_W(AW), .OFS_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_table(mode_table), .trace_en(trace_en),
    .out_base(out_base), .out_limit(out_limit), .ent_base(ent_base),
    .ent_size(ent_size), .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
    .err_clr(err_clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .cur_ofs(cur_ofs), .op_err(op_err),
    .region_adv(region_adv)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model update
  always @(posedge clk) begin
    bit acc;
    bit bad;
    if (!rst_n) begin
      m_ofs = 0; m_err = 0; m_en_q = 0; m_adv = 0;
    end else begin
      acc = wr_valid && trace_en && m_en_q && !m_err;
      bad = mode_table ? (m_ofs >= longint'(ent_size)) : (m_ofs > longint'(out_limit));
      m_adv = acc && mode_table && (m_ofs + 1 >= longint'(ent_size));
      if (trace_en && !m_en_q && bad) m_err = 1;
      else if (err_clr) m_err = 0;
      if (!trace_en && ofs_wr) m_ofs = longint'(ofs_wdata);
      else if (acc) begin
        if (mode_table) m_ofs = (m_ofs + 1 >= longint'(ent_size)) ? 0 : m_ofs + 1;
        else            m_ofs = (m_ofs == longint'(out_limit)) ? 0 : m_ofs + 1;
      end
      m_en_q = trace_en;
    end
  end

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    logic [AW-1:0] e_addr;
    bit e_rdy;
    if (!done) begin
      e_addr = (mode_table ? ent_base : out_base) + AW'(m_ofs);
      e_rdy  = trace_en && m_en_q && !m_err;
      if (!rst_n) begin
        chk(cur_ofs == 0 && op_err == 0 && region_adv == 0 && wr_ready == 0,
            "R1", "reset state", {cur_ofs, op_err, region_adv, wr_ready}, 0);
      end else begin
        chk(wr_addr == e_addr, mode_table ? "R3" : "R2", "wr_addr", wr_addr, e_addr);
        chk(cur_ofs == OW'(m_ofs), "R4 R5 R6 R11", "cur_ofs", cur_ofs, m_ofs);
        chk(op_err == m_err, "R7 R8 R9 R12", "op_err", op_err, m_err);
        chk(wr_ready == e_rdy, "R10", "wr_ready", wr_ready, e_rdy);
        chk(region_adv == m_adv, "R6", "region_adv", region_adv, m_adv);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load(input logic [OW-1:0] v);
    ofs_wr = 1'b1; ofs_wdata = v;
    cyc(1);
    ofs_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // single-region mode, streaming with gaps, wrap at limit
    out_base  = 48'h0000_1234_5000;
    out_limit = 32'd5;
    load(32'd3);
    chk(cur_ofs == 3, "R11", "load while off", cur_ofs, 3);
    trace_en = 1'b1;
    for (int i = 0; i < 14; i++) begin
      wr_valid = (i % 3 != 0);
      cyc(1);
    end
    wr_valid = 1'b0;
    trace_en = 1'b0;
    cyc(1);

    // boundary: offset equal to limit is legal
    load(32'd5);
    trace_en = 1'b1;
    cyc(2);
    chk(op_err == 0, "R7", "ofs==limit legal", op_err, 0);
    wr_valid = 1'b1;
    cyc(1);
    wr_valid = 1'b0;
    chk(cur_ofs == 0, "R5", "wrap at limit", cur_ofs, 0);
    trace_en = 1'b0;
    cyc(1);

    // offset above limit raises error; writes blocked; load ignored
    load(32'd6);
    trace_en = 1'b1;
    cyc(2);
    chk(op_err == 1, "R7", "ofs>limit error", op_err, 1);
    wr_valid = 1'b1;
    cyc(3);
    chk(cur_ofs == 6, "R10", "blocked by error", cur_ofs, 6);
    ofs_wr = 1'b1; ofs_wdata = 32'd0;
    cyc(2);
    ofs_wr = 1'b0;
    chk(cur_ofs == 6, "R11", "load ignored while on", cur_ofs, 6);
    err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;
    out_limit = 32'd2;
    cyc(4);
    chk(op_err == 0, "R12", "no recheck while on", op_err, 0);
    wr_valid = 1'b0;
    trace_en = 1'b0;
    cyc(1);

    // clear coincides with failed check: set wins
    load(32'd9);
    trace_en = 1'b1; err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;
    cyc(1);
    chk(op_err == 1, "R9", "set beats clear", op_err, 1);
    cyc(2);
    chk(op_err == 1, "R9", "sticky", op_err, 1);
    trace_en = 1'b0; err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;

    // table mode: size boundary and region advance
    mode_table = 1'b1;
    ent_base   = 48'h00AB_0000_0000;
    ent_size   = 32'd4;
    load(32'd3);
    trace_en = 1'b1;
    cyc(2);
    chk(op_err == 0, "R8", "ofs==size-1 legal", op_err, 0);
    chk(wr_addr == 48'h00AB_0000_0003, "R3", "table address", wr_addr, 48'h00AB_0000_0003);
    wr_valid = 1'b1;
    cyc(1);
    chk(region_adv == 1 && cur_ofs == 0, "R6", "advance at end", {region_adv, cur_ofs}, 33'h1_0000_0000);
    for (int i = 0; i < 10; i++) begin
      wr_valid = (i != 4);
      cyc(1);
    end
    wr_valid = 1'b0;
    trace_en = 1'b0;
    cyc(1);
    load(32'd4);
    trace_en = 1'b1;
    cyc(2);
    chk(op_err == 1, "R8", "ofs==size error", op_err, 1);
    trace_en = 1'b0; err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;

    // size of one: every byte advances the region
    ent_size = 32'd1;
    load(32'd0);
    trace_en = 1'b1;
    cyc(1);
    wr_valid = 1'b1;
    cyc(5);
    wr_valid = 1'b0;
    trace_en = 1'b0;
    cyc(2);

    finish_run();
  end
endmodule